// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters that share one count-enable tick, which is normally about 1.193182 MHz (one tick is roughly 0.838 µs). Each channel runs as a rate generator. It divides the tick by a programmed reload value, gives one output pulse per period, and reloads by itself. Channel 0's output is brought out as an interrupt request. Channel 2 advances only while an external gate enable is high. Channels 0 and 1 are always enabled.

Software reaches the block through a byte-wide register window. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is the control port. A control byte either programs a channel or freezes a snapshot of its running count. A program byte is followed by the reload value, written low byte then high byte on that channel's data port. A freeze byte lets the count be read back, low byte then high byte, while the counter keeps running. Control bytes that ask for a counting style or access pattern this block does not implement are dropped, and a one-cycle error flag is raised.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset, all three channel outputs (`ch_out`) are high, `irq_out` and `mode_err` are low, and no channel counts until it has been programmed.
- R2: A byte written to address 3 is decoded as follows: bits 7:6 pick the channel, bits 5:4 the access kind, bits 3:1 the operating mode and bit 0 the number system. Channel 0 to 2 with access 11, mode 010 and bit 0 clear is a program word. It stops that channel and drives its output high until a new reload value arrives.
- R3: The data port of a channel is the address equal to its number. The first byte written after a program word is the low reload byte and the second is the high byte. The channel holds its count and keeps its output high until the high byte is written. The first tick after that loads the reload value into the counter.
- R4: Each later tick lowers the count by one. While the count is 1, the channel output is low for exactly one tick, and the next tick loads the reload value again. The period is therefore the reload value in ticks. Reload values of 1 are not used.
- R5: A reload value of 0 acts as 65536: after it is loaded, the count reads 0x0000, and the next tick gives 0xFFFF.
- R6: `irq_out` is high exactly while channel 0's output is low.
- R7: Channel 2 neither counts nor performs its pending load while `gate_en` is low. It resumes from the held value when `gate_en` returns high.
- R8: A control byte with access 00 and channel 0 to 2 freezes that channel's current count. The next two data-port reads return the frozen value, low byte then high byte, while the counter keeps running. A second freeze byte sent before the high byte has been read is ignored.
- R9: With no snapshot pending, data-port reads return the live count, alternating low byte then high byte.
- R10: A control byte is ignored, and `mode_err` is high for the one cycle after the write, if it selects channel 3, uses access 01 or 10, or uses access 11 with a mode other than 010 or with bit 0 set. Freeze bytes and valid program bytes leave `mode_err` low.
- R11: Reads of address 3 return 0x00. Channel outputs change only on a cycle with a tick or a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count-enable tick, one clock wide |
| gate_en | input | 1 | Count enable for channel 2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; advances the byte order of a data port |
| addr | input | 2 | Register address: 0 to 2 data ports, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid in the cycle of `rd_en` |
| ch_out | output | 3 | Channel outputs, idle high, low for one tick per period |
| irq_out | output | 1 | Interrupt request from channel 0 |
| mode_err | output | 1 | One-cycle flag for an unsupported control byte |

## Verification
The assertions assume the bus carries one operation per cycle, that no reload value of 1 is ever written, and that `tick_en` changes only through the bench. With those assumptions, the output pulse of a running channel ends on the tick after it begins, and nothing moves in an idle cycle. The stimulus writes only reload values of 0 or at least 5. It gives each read or write its own cycle. In the freeze and gate tests it pulses single ticks, so every expected count can be worked out from the number of ticks applied. The tick runs freely only in the final period measurement.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_t;

  localparam logic [2:0] MODE_RATE = 3'b010;

endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_q_n = s1_q;
endmodule

// File: rtl/pit_ctl_dec.sv
module pit_ctl_dec
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              wr_ctl,
  input  logic [7:0]        wbyte,
  output logic [NUM_CH-1:0] prog_vec,
  output logic [NUM_CH-1:0] snap_vec,
  output logic              bad
);
  ctl_t cw;
  logic sel_ok, is_prog, is_snap;

  always_comb begin
    cw      = ctl_t'(wbyte);
    sel_ok  = (int'(cw.sel) < NUM_CH);
    is_snap = sel_ok && (cw.acc == ACC_SNAP);
    is_prog = sel_ok && (cw.acc == ACC_WORD) && (cw.mode == MODE_RATE) && !cw.bcd;
    bad     = wr_ctl && !is_snap && !is_prog;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign prog_vec[i] = wr_ctl && is_prog && (int'(cw.sel) == i);
    assign snap_vec[i] = wr_ctl && is_snap && (int'(cw.sel) == i);
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter  int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             prog,
  input  logic             snap_cmd,
  input  logic             wr_data,
  input  logic             rd_pop,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             out_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             armed_q, armed_d, pend_q, pend_d;
  logic             wr_hi_q, wr_hi_d, snap_q, snap_d, rd_hi_q, rd_hi_d;
  logic [BUS_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0] reload_q, reload_d, cnt_q, cnt_d, frz_q, frz_d, src;

  always_comb begin
    armed_d  = armed_q;
    pend_d   = pend_q;
    wr_hi_d  = wr_hi_q;
    snap_d   = snap_q;
    rd_hi_d  = rd_hi_q;
    lo_d     = lo_q;
    reload_d = reload_q;
    cnt_d    = cnt_q;
    frz_d    = frz_q;

    if (tick && gate && armed_q) begin
      if (pend_q) begin
        cnt_d  = reload_q;
        pend_d = 1'b0;
      end else if (cnt_q == ONE) begin
        cnt_d = reload_q;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end

    if (prog) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
      wr_hi_d = 1'b0;
      snap_d  = 1'b0;
      rd_hi_d = 1'b0;
    end

    if (wr_data) begin
      if (wr_hi_q) begin
        reload_d = {wdata, lo_q};
        armed_d  = 1'b1;
        pend_d   = 1'b1;
        wr_hi_d  = 1'b0;
      end else begin
        lo_d    = wdata;
        wr_hi_d = 1'b1;
      end
    end

    if (snap_cmd && !snap_q) begin
      snap_d = 1'b1;
      frz_d  = cnt_q;
    end

    if (rd_pop) begin
      if (rd_hi_q) begin
        rd_hi_d = 1'b0;
        snap_d  = 1'b0;
      end else begin
        rd_hi_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      wr_hi_q  <= 1'b0;
      snap_q   <= 1'b0;
      rd_hi_q  <= 1'b0;
      lo_q     <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      frz_q    <= '0;
    end else begin
      armed_q  <= armed_d;
      pend_q   <= pend_d;
      wr_hi_q  <= wr_hi_d;
      snap_q   <= snap_d;
      rd_hi_q  <= rd_hi_d;
      lo_q     <= lo_d;
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      frz_q    <= frz_d;
    end
  end

  assign src   = snap_q ? frz_q : cnt_q;
  assign rdata = rd_hi_q ? src[CNT_W-1:BUS_W] : src[BUS_W-1:0];
  assign out_n = !(armed_q && !pend_q && (cnt_q == ONE));
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer #(
  parameter  int NUM_CH   = 3,
  parameter  int BUS_W    = 8,
  parameter  int IRQ_CH   = 0,
  parameter  int GATED_CH = 2,
  localparam int ADDR_W   = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic [NUM_CH-1:0] ch_out,
  output logic              irq_out,
  output logic              mode_err
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

  logic              rst_q_n, wr_ctl, bad, err_d;
  logic [NUM_CH-1:0] prog_vec, snap_vec, out_n;
  logic [BUS_W-1:0]  ch_rdata [NUM_CH];

  pit_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign wr_ctl = wr_en && (addr == CTL_ADDR);

  pit_ctl_dec #(.NUM_CH(NUM_CH)) u_dec (
    .wr_ctl(wr_ctl), .wbyte(wdata[7:0]),
    .prog_vec(prog_vec), .snap_vec(snap_vec), .bad(bad)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic gate_i;
    if (i == GATED_CH) begin : g_gated
      assign gate_i = gate_en;
    end else begin : g_free
      assign gate_i = 1'b1;
    end

    pit_channel #(.BUS_W(BUS_W)) u_ch (
      .clk(clk), .rst_n(rst_q_n), .tick(tick_en), .gate(gate_i),
      .prog(prog_vec[i]), .snap_cmd(snap_vec[i]),
      .wr_data(wr_en && (addr == ADDR_W'(i))),
      .rd_pop(rd_en && (addr == ADDR_W'(i))),
      .wdata(wdata), .rdata(ch_rdata[i]), .out_n(out_n[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = ch_rdata[i];
    end
  end

  assign err_d = bad;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) mode_err <= 1'b0;
    else          mode_err <= err_d;
  end

  assign ch_out  = out_n;
  assign irq_out = !out_n[IRQ_CH];
endmodule

// File: rtl/prog_interval_timer_chk.sv
module prog_interval_timer_chk #(
  parameter  int NUM_CH = 3,
  parameter  int BUS_W  = 8,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  rdata,
  input logic [NUM_CH-1:0] ch_out,
  input logic              irq_out,
  input logic              mode_err
);
  localparam logic [ADDR_W-1:0] CTL = ADDR_W'(NUM_CH);

  // R4: the interrupt pulse lasts one tick
  p_pulse_one_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && tick_en && !wr_en |=> !irq_out);

  // R11: outputs hold in an idle cycle
  p_out_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !wr_en |=> $stable(ch_out));

  // R10: the error flag follows a control write
  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(wr_en && (addr == CTL)));

  // R11: the control address reads as zero
  p_ctl_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == CTL) |-> (rdata == '0));

  // R9: read data holds after an idle cycle at the same address
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_en && !wr_en && !tick_en) && $stable(addr) |-> $stable(rdata));
endmodule

bind prog_interval_timer prog_interval_timer_chk #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/sim_prog_interval_timer.sv
module sim_prog_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, gate_en = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] ch_out;
  logic       irq_out, mode_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] q_exp [$];
  string      q_tag [$];

  always #4 clk = ~clk;

  prog_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_en(gate_en),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_out(ch_out), .irq_out(irq_out), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    addr = a; rd_en = 1'b1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      cyc();
      tick_en = 1'b0;
    end
  endtask

  // monitor: pops one expected byte per read cycle
  always @(negedge clk) begin
    if (rd_en) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R9 unexpected read", rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit samp [40];
    int last_rise, rises, gap_bad, wide_bad, irq_mis;
    logic [2:0] snap_out;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    chk(ch_out == 3'b111, "R1 outputs idle", ch_out, 3'b111);
    chk(!irq_out, "R1 irq low", irq_out, 0);
    chk(!mode_err, "R1 err low", mode_err, 0);
    ticks(4);
    chk(ch_out == 3'b111, "R1 no count unprogrammed", ch_out, 3'b111);

    // R2 / R3 program ch1, low byte only
    wr(2'd3, 8'h74);
    chk(!mode_err, "R2 program word accepted", mode_err, 0);
    wr(2'd1, 8'h34);
    ticks(3);
    chk(ch_out[1], "R3 output high before high byte", ch_out[1], 1);
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h00, "R3 no count before high byte lo");
    rd(2'd1, 8'h00, "R3 no count before high byte hi");
    wr(2'd1, 8'h12);
    ticks(1);
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h34, "R3 loaded lo");
    rd(2'd1, 8'h12, "R3 loaded hi");

    // R8 snapshot frozen, second freeze ignored
    wr(2'd3, 8'h40);
    ticks(5);
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h34, "R8 frozen lo");
    rd(2'd1, 8'h12, "R8 frozen hi");
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h2F, "R8 new snapshot lo");
    rd(2'd1, 8'h12, "R8 new snapshot hi");

    // R9 live reads
    rd(2'd1, 8'h2F, "R9 live lo");
    rd(2'd1, 8'h12, "R9 live hi");

    // R10 unsupported words
    wr(2'd3, 8'h76);
    chk(mode_err, "R10 mode 3 flagged", mode_err, 1);
    wr(2'd3, 8'h75);
    chk(mode_err, "R10 bcd flagged", mode_err, 1);
    wr(2'd3, 8'h54);
    chk(mode_err, "R10 single byte access flagged", mode_err, 1);
    wr(2'd3, 8'hF4);
    chk(mode_err, "R10 channel 3 flagged", mode_err, 1);
    ticks(1);
    rd(2'd1, 8'h2E, "R10 ch1 unaffected lo");
    rd(2'd1, 8'h12, "R10 ch1 unaffected hi");
    wr(2'd3, 8'h40);
    chk(!mode_err, "R10 freeze not flagged", mode_err, 0);
    rd(2'd1, 8'h2E, "R10 snapshot lo");
    rd(2'd1, 8'h12, "R10 snapshot hi");

    // R5 reload zero
    wr(2'd3, 8'h74);
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h00);
    ticks(1);
    rd(2'd1, 8'h00, "R5 loaded zero lo");
    rd(2'd1, 8'h00, "R5 loaded zero hi");
    ticks(1);
    rd(2'd1, 8'hFF, "R5 wrap lo");
    rd(2'd1, 8'hFF, "R5 wrap hi");

    // R7 gate on channel 2
    wr(2'd3, 8'hB4);
    wr(2'd2, 8'h64);
    wr(2'd2, 8'h00);
    gate_en = 1'b0;
    ticks(3);
    rd(2'd2, 8'h00, "R7 load held lo");
    rd(2'd2, 8'h00, "R7 load held hi");
    gate_en = 1'b1;
    ticks(1);
    gate_en = 1'b0;
    ticks(4);
    rd(2'd2, 8'h64, "R7 count held lo");
    rd(2'd2, 8'h00, "R7 count held hi");
    gate_en = 1'b1;
    ticks(3);
    rd(2'd2, 8'h61, "R7 resumed lo");
    rd(2'd2, 8'h00, "R7 resumed hi");

    // R11 control read and idle outputs
    rd(2'd3, 8'h00, "R11 control reads zero");
    snap_out = ch_out;
    repeat (3) cyc();
    chk(ch_out == snap_out, "R11 outputs idle", ch_out, snap_out);

    // R4 / R6 rate generator on channel 0, reload 5
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h00);
    tick_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      samp[i] = irq_out;
      if (irq_out != !ch_out[0]) irq_mis++;
    end
    tick_en = 1'b0;
    chk(irq_mis == 0, "R6 irq mirrors ch0 output", irq_mis, 0);
    last_rise = -1;
    for (int i = 1; i < 40; i++) begin
      if (samp[i] && samp[i-1]) wide_bad++;
      if (samp[i] && !samp[i-1]) begin
        if (last_rise >= 0 && (i - last_rise) != 5) gap_bad++;
        last_rise = i;
        rises++;
      end
    end
    chk(rises >= 6, "R4 pulses seen", rises, 6);
    chk(gap_bad == 0, "R4 period of five ticks", gap_bad, 0);
    chk(wide_bad == 0, "R4 one tick low", wide_bad, 0);

    cyc();
    chk(q_exp.size() == 0, "R9 all reads consumed", q_exp.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule